// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers described by a circular list of descriptors. Each descriptor is four 32-bit words. Word 0 holds command and status bits. Word 1 holds the buffer capacity in its upper half and the written byte count in its lower half. Word 2 holds the buffer start address and word 3 holds the address of the following descriptor. Software fills the descriptors, links the last one back to the first, and hands each one to the engine by setting the ownership bit.

When the first byte of a frame arrives, the engine reads the current descriptor over a simple memory master port. Read data returns one cycle after the request, and writes take byte strobes. If the engine owns the descriptor, it packs the frame bytes into words. The frame data starts two zero bytes into the buffer, so the network header that follows lands on a word boundary. The engine then writes the count word. It writes the status word last, and that write clears the ownership bit. It may then pulse an interrupt, and it moves to the descriptor named by the next pointer. A frame that finds no owned descriptor is consumed and discarded, and a no-resource pulse reports it. Every frame uses exactly one descriptor. A frame too long for its buffer is cut short and marked in error rather than spread over several descriptors.

Top module: `rxr_ring_rx`

## Requirements
- R1: After reset, `cur_ptr` equals `ring_base`, and `in_ready`, `irq` and `nores` are all low.
- R2: The engine fills a descriptor only if bit 31 of word 0 is set. Its write-back of word 0 clears bit 31 and keeps bit 23.
- R3: Buffer byte offsets 0 and 1 are written as zero, and frame byte i is written at offset 2+i. No buffer byte at or beyond the final byte count is written.
- R4: Word 1 is written back with the capacity in bits 31:16 unchanged and the byte count, frame length plus two, in bits 15:0.
- R5: Every completed descriptor has both bit 17 (first) and bit 16 (last) set in its written-back word 0.
- R6: Bit 15 (error summary) of the written-back word 0 is set if `in_err` was high on any byte of the frame.
- R7: If frame length plus two exceeds the capacity, the count is the capacity and only the first capacity-minus-two bytes are stored. Bit 15 is then set.
- R8: Word 1 is written in the cycle just before word 0, and the word 0 write is the last memory write made for the descriptor.
- R9: `irq` pulses for one cycle right after the word 0 write, exactly when bit 23 of that descriptor was set.
- R10: After each completed descriptor, `cur_ptr` takes the value of word 3, so the ring wraps through the link of its last entry.
- R11: A frame that finds bit 31 clear is accepted byte by byte and discarded. It causes no memory write and leaves `cur_ptr` unchanged, and `nores` pulses for one cycle after its last byte.
- R12: `in_ready` is low while the engine fetches or writes back a descriptor, and it is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Address of the first descriptor, loaded at reset |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Receive error flagged on this byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Descriptor-complete interrupt pulse |
| nores | output | 1 | Frame dropped for lack of an owned descriptor |
| cur_ptr | output | ADDR_W | Address of the current descriptor |

## Verification
A wrong byte position in the packer shows up in the buffer contents as soon as the first word of the frame is written. A wrong count or missing truncation shows up in word 1 and in the guard byte beyond the count when the frame closes. A wrong ownership decision shows at once. Either buffer writes appear for a descriptor that was not owned, or `nores` pulses when it should not. Errors in the write-back order or the pointer update show within the two cycles after the last byte, through the last address written, the `irq` pulse and `cur_ptr`. Random lengths, capacities and error positions are mixed with exact-fit, one-over and non-owned frames, and the stream wraps the ring several times.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int CNT_W     = 16;
    localparam int LANES     = 4;
    localparam int PAD_BYTES = 2;
    localparam int OWN_BIT   = 31;
    localparam int IE_BIT    = 23;
    localparam int FIRST_BIT = 17;
    localparam int LAST_BIT  = 16;
    localparam int ES_BIT    = 15;

    typedef struct packed {
        logic [31:0]      cmd;
        logic [CNT_W-1:0] size;
        logic [31:0]      bptr;
        logic [31:0]      nxt;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DATA, ST_DROP, ST_WB_CNT, ST_WB_STS
    } st_e;

    function automatic logic [31:0] close_status(logic [31:0] cmd, logic es);
        logic [31:0] r;
        r            = cmd;
        r[OWN_BIT]   = 1'b0;
        r[FIRST_BIT] = 1'b1;
        r[LAST_BIT]  = 1'b1;
        r[ES_BIT]    = es;
        return r;
    endfunction
endpackage

// File: rtl/rxr_desc_fetch.sv
`timescale 1ns/1ps
module rxr_desc_fetch
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rdata,
    output logic              done,
    output desc_t             desc
);
    localparam int WORDS = 4;

    logic       busy;
    logic [2:0] iss;
    logic       pend_v;
    logic [1:0] pend_i;

    assign rd_req  = busy && (iss < 3'(WORDS));
    assign rd_addr = base + ADDR_W'({iss[1:0], 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            iss    <= '0;
            pend_v <= 1'b0;
            pend_i <= '0;
            done   <= 1'b0;
            desc   <= '0;
        end else begin
            done   <= 1'b0;
            pend_v <= rd_req;
            pend_i <= iss[1:0];
            if (start) begin
                busy <= 1'b1;
                iss  <= '0;
            end else if (rd_req) begin
                iss <= iss + 3'd1;
            end
            if (pend_v) begin
                case (pend_i)
                    2'd0:    desc.cmd  <= rdata;
                    2'd1:    desc.size <= rdata[31:16];
                    2'd2:    desc.bptr <= rdata;
                    default: desc.nxt  <= rdata;
                endcase
                if (pend_i == 2'd3) begin
                    done <= 1'b1;
                    busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rxr_pack.sv
`timescale 1ns/1ps
module rxr_pack
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             push,
    input  logic             flush,
    input  logic [1:0]       lane,
    input  logic [7:0]       din,
    output logic             wr,
    output logic [8*LANES-1:0] wdata,
    output logic [LANES-1:0] wstrb
);
    logic [8*LANES-1:0] dq;
    logic [LANES-1:0]   sq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata[8*g +: 8] = (lane == 2'(g)) ? din : dq[8*g +: 8];
        assign wstrb[g]        = (lane == 2'(g)) | sq[g];
    end

    assign wr = push && ((lane == 2'(LANES - 1)) || flush);

    always_ff @(posedge clk) begin
        if (rst) begin
            dq <= '0;
            sq <= '0;
        end else if (init) begin
            dq <= '0;
            sq <= LANES'((1 << PAD_BYTES) - 1);
        end else if (push) begin
            if (wr) begin
                dq <= '0;
                sq <= '0;
            end else begin
                dq <= wdata;
                sq <= wstrb;
            end
        end
    end
endmodule

// File: rtl/rxr_ring_rx.sv
`timescale 1ns/1ps
module rxr_ring_rx
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic [31:0]       mem_rdata,
    output logic              irq,
    output logic              nores,
    output logic [ADDR_W-1:0] cur_ptr
);
    st_e              st;
    desc_t            d;
    logic [CNT_W-1:0] cnt;
    logic             trunc, errs;
    logic             f_start, f_done, f_req;
    logic [ADDR_W-1:0] f_addr;
    logic             acc, push, flush, pk_init, pk_wr;
    logic [31:0]      pk_wdata;
    logic [3:0]       pk_wstrb;

    assign f_start = (st == ST_IDLE) && in_valid;
    assign in_ready = (st == ST_DATA) || (st == ST_DROP);
    assign acc     = (st == ST_DATA) && in_valid;
    assign push    = acc && (cnt < d.size);
    assign flush   = in_last || ((cnt + CNT_W'(1)) == d.size);
    assign pk_init = (st == ST_FETCH) && f_done && d.cmd[OWN_BIT];

    rxr_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst(rst), .start(f_start), .base(cur_ptr),
        .rd_req(f_req), .rd_addr(f_addr), .rdata(mem_rdata),
        .done(f_done), .desc(d)
    );

    rxr_pack u_pack (
        .clk(clk), .rst(rst), .init(pk_init), .push(push), .flush(flush),
        .lane(cnt[1:0]), .din(in_data),
        .wr(pk_wr), .wdata(pk_wdata), .wstrb(pk_wstrb)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = '0;
        case (st)
            ST_FETCH: begin
                mem_req  = f_req;
                mem_addr = f_addr;
            end
            ST_DATA: begin
                mem_req   = pk_wr;
                mem_we    = pk_wr;
                mem_addr  = ADDR_W'(d.bptr) + ADDR_W'({cnt[CNT_W-1:2], 2'b00});
                mem_wdata = pk_wdata;
                mem_wstrb = pk_wstrb;
            end
            ST_WB_CNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + ADDR_W'(4);
                mem_wdata = {d.size, cnt};
                mem_wstrb = 4'hF;
            end
            ST_WB_STS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr;
                mem_wdata = close_status(d.cmd, errs | trunc);
                mem_wstrb = 4'hF;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            trunc   <= 1'b0;
            errs    <= 1'b0;
            irq     <= 1'b0;
            nores   <= 1'b0;
            cur_ptr <= ring_base;
        end else begin
            irq   <= 1'b0;
            nores <= 1'b0;
            case (st)
                ST_IDLE: if (in_valid) st <= ST_FETCH;
                ST_FETCH: if (f_done) begin
                    if (d.cmd[OWN_BIT]) begin
                        st    <= ST_DATA;
                        cnt   <= CNT_W'(PAD_BYTES);
                        trunc <= 1'b0;
                        errs  <= 1'b0;
                    end else begin
                        st <= ST_DROP;
                    end
                end
                ST_DATA: if (acc) begin
                    errs <= errs | in_err;
                    if (push) cnt <= cnt + CNT_W'(1);
                    else      trunc <= 1'b1;
                    if (in_last) st <= ST_WB_CNT;
                end
                ST_WB_CNT: st <= ST_WB_STS;
                ST_WB_STS: begin
                    irq     <= d.cmd[IE_BIT];
                    cur_ptr <= ADDR_W'(d.nxt);
                    st      <= ST_IDLE;
                end
                ST_DROP: if (in_valid && in_last) begin
                    nores <= 1'b1;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R8
    sts_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr == cur_ptr)
        |-> $past(mem_req && mem_we && mem_addr == cur_ptr + ADDR_W'(4)));

    // R10
    ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_ptr) |-> $past(mem_req && mem_we && mem_addr == cur_ptr));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_we && mem_addr == cur_ptr && !mem_wdata[OWN_BIT]
                      && mem_wdata[IE_BIT]));

    // R11
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DROP) |-> !mem_req);

    // R7
    cnt_room_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (cnt <= d.size));
endmodule

// File: tb/rxr_ring_rx_bench.sv
`timescale 1ns/1ps
module rxr_ring_rx_bench;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] IE  = 32'h0080_0000;
    localparam logic [31:0] FL  = 32'h0003_0000;
    localparam logic [31:0] ES  = 32'h0000_8000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] ring_base = 32'h0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_ready, mem_req, mem_we, irq, nores;
    logic [31:0] mem_addr, mem_wdata, cur_ptr;
    logic [31:0] mem_rdata = 32'h0;
    logic [3:0]  mem_wstrb;

    logic [31:0] mem [0:1023];
    logic        sw_we = 1'b0;
    logic [31:0] sw_addr = 32'h0, sw_data = 32'h0;
    int unsigned wr_count = 0;
    logic [31:0] last_wr = 32'h0;
    int unsigned irq_n = 0, nores_n = 0;
    int unsigned n_tests = 0, n_fail = 0;
    int          cur_idx = 0;
    logic [7:0]  fr [0:127];

    rxr_ring_rx u_rxr_ring_rx (
        .clk(clk), .rst(rst), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_rdata(mem_rdata), .irq(irq), .nores(nores), .cur_ptr(cur_ptr)
    );

    always @(posedge clk) begin
        if (sw_we) mem[sw_addr[11:2]] <= sw_data;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                wr_count <= wr_count + 1;
                last_wr  <= mem_addr;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    always @(negedge clk) begin
        if (irq)   irq_n   <= irq_n + 1;
        if (nores) nores_n <= nores_n + 1;
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    task automatic sw_wr(logic [31:0] a, logic [31:0] v);
        sw_we = 1'b1; sw_addr = a; sw_data = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic arm(int idx, int size, bit ie);
        int d = idx * 16;
        sw_wr(d,      OWN | (ie ? IE : 32'h0));
        sw_wr(d + 4,  {16'(size), 16'h0});
        sw_wr(d + 8,  32'(256 * (idx + 1)));
        sw_wr(d + 12, 32'(((idx + 1) % 3) * 16));
        for (int w = 0; w < 32; w++) sw_wr(256 * (idx + 1) + 4 * w, 32'hAAAA_AAAA);
    endtask

    task automatic send(int len, int errpos);
        for (int i = 0; i < len; i++) begin
            bit r;
            in_valid = 1'b1; in_data = fr[i];
            in_last = (i == len - 1); in_err = (i == errpos);
            do begin
                r = in_ready;
                @(negedge clk);
            end while (!r);
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    endtask

    task automatic run_frame(int len, int size, bit ie, int errpos);
        int d = cur_idx * 16;
        int b = 256 * (cur_idx + 1);
        int stored, cnt, bad;
        bit es;
        int unsigned irq0;
        arm(cur_idx, size, ie);
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
        irq0 = irq_n;
        send(len, errpos);
        repeat (6) @(negedge clk);
        stored = (len < size - 2) ? len : size - 2;
        cnt    = stored + 2;
        es     = (errpos >= 0) || (len > size - 2);
        chk(mem[d >> 2] == ((ie ? IE : 32'h0) | FL | (es ? ES : 32'h0)),
            "R2 R5 R6 R7 status word", mem[d >> 2], (ie ? IE : 32'h0) | FL | (es ? ES : 32'h0));
        chk(mem[(d >> 2) + 1] == {16'(size), 16'(cnt)}, "R4 R7 count word",
            mem[(d >> 2) + 1], {16'(size), 16'(cnt)});
        chk(mbyte(b) == 8'h0 && mbyte(b + 1) == 8'h0, "R3 pad bytes",
            {mbyte(b), mbyte(b + 1)}, 32'h0);
        bad = 0;
        for (int i = 0; i < stored; i++) if (mbyte(b + 2 + i) != fr[i]) bad++;
        chk(bad == 0, "R3 R7 data bytes", bad, 0);
        if (cnt < 128) chk(mbyte(b + cnt) == 8'hAA, "R3 guard byte", mbyte(b + cnt), 8'hAA);
        chk(last_wr == 32'(d), "R8 last write", last_wr, d);
        chk(cur_ptr == 32'(((cur_idx + 1) % 3) * 16), "R10 pointer", cur_ptr,
            ((cur_idx + 1) % 3) * 16);
        chk(irq_n - irq0 == (ie ? 1 : 0), "R9 irq", irq_n - irq0, ie);
        chk(in_ready == 1'b0, "R12 ready idle", in_ready, 0);
        cur_idx = (cur_idx + 1) % 3;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(cur_ptr == ring_base, "R1 reset pointer", cur_ptr, ring_base);
        chk(!in_ready && !irq && !nores, "R1 reset outputs", {in_ready, irq, nores}, 0);
        for (int k = 0; k < 3; k++) arm(k, 64, 1'b1);

        run_frame(10, 64, 1'b1, -1);
        run_frame(62, 64, 1'b1, -1);   // exact fit
        run_frame(63, 64, 1'b0, -1);   // one byte over, R7
        run_frame(1, 8, 1'b1, 0);      // R6 error on only byte
        run_frame(40, 16, 1'b1, 30);   // R6 error on a truncated byte

        // R11: descriptor not owned
        begin
            int unsigned w0, n0;
            logic [31:0] p0;
            sw_wr(cur_idx * 16, 32'h0);
            w0 = wr_count; n0 = nores_n; p0 = cur_ptr;
            for (int i = 0; i < 20; i++) fr[i] = 8'($urandom);
            send(20, -1);
            repeat (6) @(negedge clk);
            chk(nores_n - n0 == 1, "R11 nores pulse", nores_n - n0, 1);
            chk(wr_count == w0, "R11 no writes", wr_count - w0, 0);
            chk(cur_ptr == p0, "R11 pointer held", cur_ptr, p0);
            chk(mem[cur_idx * 4] == 32'h0, "R11 R2 status untouched", mem[cur_idx * 4], 0);
        end

        for (int t = 0; t < 24; t++) begin
            int size = 8 + 4 * int'($urandom % 30);
            int len  = 1 + int'($urandom % (size + 4));
            int ep   = (($urandom % 4) == 0) ? int'($urandom % len) : -1;
            run_frame(len, size, 1'($urandom), ep);
        end

        summary();
        $finish;
    end
endmodule